// File: doc/BRIEF.md
# Core PC Sampling Debug Register Block

This block is a small memory-mapped register slave that an external debugger or a profiling agent uses to take non-intrusive samples of a processor core's program counter. It sits on a simple APB-style port with no wait states. On the core side it watches several inputs: the live 64-bit program counter, the context identifier, the security, exception-level and execution-width state, the virtual machine identifier, a flag that marks debug state or prohibited profiling, the double-lock state and the power acknowledge from the power controller.

A read of the low PC word is the trigger. The same transfer freezes the upper PC word, the context identifier and the virtualization status word into holding registers, so that the agent can fetch a consistent set with later reads. An OS lock, a double lock or a powered-down core shuts off the sample registers. A debug-state or profiling-prohibited condition makes the low word read as all ones. The block also holds the power-up and keep-powered request bits, which drive the power controller directly, a power status word and two fixed feature-identification words.

Top module: `pcs_debug_regs`

## Requirements
- R1: After reset the OS lock is set, the power control bits and both request outputs are 0, and the held upper-PC, context and virtualization registers are 0.
- R2: With access allowed and sampling not prohibited, a read of offset 0x0A0 returns bits 31:0 of the live program counter in the same transfer. pready is always 1.
- R3: Such a read of 0x0A0 captures PC bits 63:32, the context identifier and the virtualization word. Later reads of 0x0AC, 0x0A4 and 0x0A8 return the captured values even after the core inputs change.
- R4: While core_prohibit is 1 and access is allowed, a read of 0x0A0 returns 0xFFFFFFFF and captures nothing.
- R5: While the OS lock is set, the double lock input is 1 or pwr_ack is 0, reads of the four sample offsets return 0 and capture nothing.
- R6: A write to 0x300 loads the OS lock from write-data bit 0: zero clears the lock and one sets it.
- R7: Offset 0x310 holds two read/write bits. Bit 3 drives pwr_up_req and bit 0 drives no_pdn_req. All other bits read 0.
- R8: Offset 0x314 is readable at all times. Bit 0 equals pwr_ack and bit 6 equals core_dlock. All other bits read 0.
- R9: The virtualization word places non-secure state at bit 31, level 2 at bit 30, level 3 at bit 29, 64-bit width at bit 28 and the 8-bit VMID at bits 7:0.
- R10: Offset 0xFC8 bits 3:0 read SAMPLE_LEVEL, where 1 means PC only, 2 adds the context and 3 adds the virtualization word. Offset 0xFC4 bits 3:0 read PC_OFS_MODE (default 0). A sample register above the level reads 0.
- R11: Reads of unmapped offsets return 0, and writes to unmapped or read-only offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| core_pc | input | 64 | Live program counter |
| core_ctx | input | 32 | Context identifier |
| core_ns | input | 1 | Non-secure state |
| core_el2 | input | 1 | Executing at level 2 |
| core_el3 | input | 1 | Executing at level 3 |
| core_aa64 | input | 1 | 64-bit execution width |
| core_vmid | input | 8 | Virtual machine identifier |
| core_prohibit | input | 1 | Debug state or profiling prohibited |
| core_dlock | input | 1 | OS double lock set |
| pwr_ack | input | 1 | Core powered up, from power controller |
| pwr_up_req | output | 1 | Power-up request to power controller |
| no_pdn_req | output | 1 | Keep-powered request to power controller |

## Verification
On every cycle, the assertions check four things: the capture registers load exactly the core values present on a capture strobe, they hold their contents on every other cycle, the request outputs change only after a write to the power control offset, and a zero written to the lock offset clears the lock. Only the bench scenarios can show the rest at the read port. That includes the all-ones response under prohibition, the zero response under each of the three blocking conditions, the field layout of the virtualization word, the identification values and the silence of unmapped offsets.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam logic [11:0] OFS_PCLO = 12'h0A0;
  localparam logic [11:0] OFS_CTX  = 12'h0A4;
  localparam logic [11:0] OFS_VIRT = 12'h0A8;
  localparam logic [11:0] OFS_PCHI = 12'h0AC;
  localparam logic [11:0] OFS_OSLK = 12'h300;
  localparam logic [11:0] OFS_PCTL = 12'h310;
  localparam logic [11:0] OFS_PSTS = 12'h314;
  localparam logic [11:0] OFS_ID1  = 12'hFC4;
  localparam logic [11:0] OFS_ID0  = 12'hFC8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PCLO, SEL_CTX, SEL_VIRT, SEL_PCHI,
    SEL_OSLK, SEL_PCTL, SEL_PSTS, SEL_ID1, SEL_ID0
  } reg_sel_e;

  typedef struct packed {
    logic        ns;
    logic        el2;
    logic        el3;
    logic        aa64;
    logic [19:0] rsvd;
    logic [7:0]  vmid;
  } virt_word_t;

endpackage

// File: rtl/pcs_apb_decode.sv
module pcs_apb_decode
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output reg_sel_e          sel,
  output logic              rd_stb,
  output logic              wr_stb
);

  always_comb begin
    case (paddr)
      ADDR_W'(OFS_PCLO): sel = SEL_PCLO;
      ADDR_W'(OFS_CTX):  sel = SEL_CTX;
      ADDR_W'(OFS_VIRT): sel = SEL_VIRT;
      ADDR_W'(OFS_PCHI): sel = SEL_PCHI;
      ADDR_W'(OFS_OSLK): sel = SEL_OSLK;
      ADDR_W'(OFS_PCTL): sel = SEL_PCTL;
      ADDR_W'(OFS_PSTS): sel = SEL_PSTS;
      ADDR_W'(OFS_ID1):  sel = SEL_ID1;
      ADDR_W'(OFS_ID0):  sel = SEL_ID0;
      default:           sel = SEL_NONE;
    endcase
  end

  assign rd_stb = psel && penable && !pwrite;
  assign wr_stb = psel && penable && pwrite;

endmodule

// File: rtl/pcs_sample_latch.sv
module pcs_sample_latch
  import pcs_pkg::*;
#(
  parameter int HI_W  = 32,
  parameter int CTX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [HI_W-1:0]  pc_hi_in,
  input  logic [CTX_W-1:0] ctx_in,
  input  virt_word_t       virt_in,
  output logic [HI_W-1:0]  pc_hi_q,
  output logic [CTX_W-1:0] ctx_q,
  output virt_word_t       virt_q
);

  logic [HI_W-1:0]  pc_hi_d;
  logic [CTX_W-1:0] ctx_d;
  virt_word_t       virt_d;

  always_comb begin
    pc_hi_d = pc_hi_q;
    ctx_d   = ctx_q;
    virt_d  = virt_q;
    if (cap_en) begin
      pc_hi_d = pc_hi_in;
      ctx_d   = ctx_in;
      virt_d  = virt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_hi_q <= '0;
      ctx_q   <= '0;
      virt_q  <= '0;
    end else begin
      pc_hi_q <= pc_hi_d;
      ctx_q   <= ctx_d;
      virt_q  <= virt_d;
    end
  end

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cap_en) |->
      (pc_hi_q == $past(pc_hi_in)) && (ctx_q == $past(ctx_in)) && (virt_q == $past(virt_in)));

  // R4 R5
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(cap_en) |->
      $stable(pc_hi_q) && $stable(ctx_q) && $stable(virt_q));

endmodule

// File: rtl/pcs_ctrl_regs.sv
module pcs_ctrl_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_oslk,
  input  logic        wr_pctl,
  input  logic [31:0] wdata,
  output logic        os_lock,
  output logic        pctl_up,
  output logic        pctl_nopd
);

  logic os_lock_d, pctl_up_d, pctl_nopd_d;

  always_comb begin
    os_lock_d   = os_lock;
    pctl_up_d   = pctl_up;
    pctl_nopd_d = pctl_nopd;
    if (wr_oslk) os_lock_d = wdata[0];
    if (wr_pctl) begin
      pctl_up_d   = wdata[3];
      pctl_nopd_d = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_lock   <= 1'b1;
      pctl_up   <= 1'b0;
      pctl_nopd <= 1'b0;
    end else begin
      os_lock   <= os_lock_d;
      pctl_up   <= pctl_up_d;
      pctl_nopd <= pctl_nopd_d;
    end
  end

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R6
  oslock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_oslk) && !$past(wdata[0]) |-> !os_lock);

  // R7
  pwr_req_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_pctl) |-> (pctl_up == $past(wdata[3])) && (pctl_nopd == $past(wdata[0])));

  // R7 R11
  pwr_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(wr_pctl) |-> $stable(pctl_up) && $stable(pctl_nopd));

endmodule

// File: rtl/pcs_debug_regs.sv
module pcs_debug_regs
  import pcs_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          PC_W         = 64,
  parameter int          CTX_W        = 32,
  parameter int          VMID_W       = 8,
  parameter logic [3:0]  SAMPLE_LEVEL = 4'd3,
  parameter logic [3:0]  PC_OFS_MODE  = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic [PC_W-1:0]   core_pc,
  input  logic [CTX_W-1:0]  core_ctx,
  input  logic              core_ns,
  input  logic              core_el2,
  input  logic              core_el3,
  input  logic              core_aa64,
  input  logic [VMID_W-1:0] core_vmid,
  input  logic              core_prohibit,
  input  logic              core_dlock,
  input  logic              pwr_ack,
  output logic              pwr_up_req,
  output logic              no_pdn_req
);

  localparam int HI_W = PC_W - 32;

  reg_sel_e sel;
  logic rd_stb, wr_stb;

  pcs_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  logic os_lock, pctl_up, pctl_nopd;

  pcs_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_oslk(wr_stb && sel == SEL_OSLK),
    .wr_pctl(wr_stb && sel == SEL_PCTL),
    .wdata(pwdata),
    .os_lock(os_lock), .pctl_up(pctl_up), .pctl_nopd(pctl_nopd)
  );

  logic access_ok, cap_en;
  assign access_ok = !os_lock && !core_dlock && pwr_ack;
  assign cap_en    = rd_stb && sel == SEL_PCLO && access_ok && !core_prohibit;

  virt_word_t virt_live;
  always_comb begin
    virt_live      = '0;
    virt_live.ns   = core_ns;
    virt_live.el2  = core_el2;
    virt_live.el3  = core_el3;
    virt_live.aa64 = core_aa64;
    virt_live.vmid = 8'(core_vmid);
  end

  logic [HI_W-1:0]  pc_hi_q;
  logic [CTX_W-1:0] ctx_q;
  virt_word_t       virt_q;

  pcs_sample_latch #(.HI_W(HI_W), .CTX_W(CTX_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .pc_hi_in(core_pc[PC_W-1:32]), .ctx_in(core_ctx), .virt_in(virt_live),
    .pc_hi_q(pc_hi_q), .ctx_q(ctx_q), .virt_q(virt_q)
  );

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_PCLO: if (access_ok) rd_word = core_prohibit ? 32'hFFFF_FFFF : core_pc[31:0];
      SEL_PCHI: if (access_ok) rd_word = 32'(pc_hi_q);
      SEL_CTX:  if (access_ok && SAMPLE_LEVEL >= 4'd2) rd_word = 32'(ctx_q);
      SEL_VIRT: if (access_ok && SAMPLE_LEVEL >= 4'd3) rd_word = virt_q;
      SEL_OSLK: rd_word = '0;
      SEL_PCTL: rd_word = {28'd0, pctl_up, 2'b00, pctl_nopd};
      SEL_PSTS: rd_word = {25'd0, core_dlock, 5'd0, pwr_ack};
      SEL_ID1:  rd_word = {28'd0, PC_OFS_MODE};
      SEL_ID0:  rd_word = {28'd0, SAMPLE_LEVEL};
      default:  rd_word = '0;
    endcase
  end

  assign prdata     = rd_stb ? rd_word : '0;
  assign pready     = 1'b1;
  assign pwr_up_req = pctl_up;
  assign no_pdn_req = pctl_nopd;

endmodule

// File: tb/pcs_debug_regs_test.sv
module pcs_debug_regs_test;

  logic        clk, rst_n;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic        pready;
  logic [63:0] core_pc;
  logic [31:0] core_ctx;
  logic        core_ns, core_el2, core_el3, core_aa64;
  logic [7:0]  core_vmid;
  logic        core_prohibit, core_dlock, pwr_ack;
  logic        pwr_up_req, no_pdn_req;

  int checks = 0;
  int errors = 0;

  pcs_debug_regs uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .core_pc(core_pc), .core_ctx(core_ctx), .core_ns(core_ns), .core_el2(core_el2),
    .core_el3(core_el3), .core_aa64(core_aa64), .core_vmid(core_vmid),
    .core_prohibit(core_prohibit), .core_dlock(core_dlock), .pwr_ack(pwr_ack),
    .pwr_up_req(pwr_up_req), .no_pdn_req(no_pdn_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    rdy = pready;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic r;
    check("R1 pwr_up_req", {31'd0, pwr_up_req}, 32'd0);
    check("R1 no_pdn_req", {31'd0, no_pdn_req}, 32'd0);
    bus_read(12'h310, d, r); check("R1 power control", d, 32'd0);
    bus_read(12'h0AC, d, r); check("R1/R5 locked high read", d, 32'd0);
    bus_read(12'h0A0, d, r); check("R5 os lock blocks low read", d, 32'd0);
  endtask

  task automatic t_unlock_and_sample;
    logic [31:0] d; logic r;
    bus_write(12'h300, 32'd0);
    core_pc = 64'h1234_5678_9ABC_DEF0; core_ctx = 32'hCAFE_0001;
    core_ns = 1; core_el2 = 0; core_el3 = 1; core_aa64 = 1; core_vmid = 8'h5A;
    bus_read(12'h0A0, d, r);
    check("R2/R6 low word after unlock", d, 32'h9ABC_DEF0);
    check("R2 pready", {31'd0, r}, 32'd1);
    core_pc = 64'hAAAA_BBBB_0000_1111; core_ctx = 32'h0; core_ns = 0; core_el3 = 0;
    core_aa64 = 0; core_el2 = 1; core_vmid = 8'h03;
    bus_read(12'h0AC, d, r); check("R3 captured high word", d, 32'h1234_5678);
    bus_read(12'h0A4, d, r); check("R3 captured context", d, 32'hCAFE_0001);
    bus_read(12'h0A8, d, r); check("R3/R9 captured virt word", d, 32'hB000_005A);
    bus_read(12'h0A0, d, r); check("R2 new low word", d, 32'h0000_1111);
    bus_read(12'h0A8, d, r); check("R9 el2 field", d, 32'h4000_0003);
  endtask

  task automatic t_prohibit;
    logic [31:0] d; logic r;
    core_prohibit = 1; core_pc = 64'h5555_6666_7777_8888;
    bus_read(12'h0A0, d, r); check("R4 prohibited low word", d, 32'hFFFF_FFFF);
    bus_read(12'h0AC, d, r); check("R4 no capture", d, 32'hAAAA_BBBB);
    core_prohibit = 0;
  endtask

  task automatic t_blocking;
    logic [31:0] d; logic r;
    core_dlock = 1;
    bus_read(12'h0A0, d, r); check("R5 double lock low", d, 32'd0);
    bus_read(12'h314, d, r); check("R8 status dlock", d, 32'h41);
    core_dlock = 0; pwr_ack = 0;
    bus_read(12'h0A0, d, r); check("R5 powered down low", d, 32'd0);
    bus_read(12'h314, d, r); check("R8 status off", d, 32'h0);
    pwr_ack = 1;
    bus_read(12'h0AC, d, r); check("R5 no capture while blocked", d, 32'hAAAA_BBBB);
    bus_write(12'h300, 32'd1);
    bus_read(12'h0A0, d, r); check("R6 relock", d, 32'd0);
    bus_write(12'h300, 32'd0);
  endtask

  task automatic t_power;
    logic [31:0] d; logic r;
    bus_write(12'h310, 32'hFFFF_FFFF);
    bus_read(12'h310, d, r); check("R7 control readback", d, 32'h9);
    check("R7 requests high", {30'd0, pwr_up_req, no_pdn_req}, 32'h3);
    bus_write(12'h310, 32'h0000_0008);
    check("R7 only power-up", {30'd0, pwr_up_req, no_pdn_req}, 32'h2);
    bus_write(12'h310, 32'd0);
    check("R7 requests low", {30'd0, pwr_up_req, no_pdn_req}, 32'h0);
  endtask

  task automatic t_ids_unmapped;
    logic [31:0] d; logic r;
    bus_read(12'hFC8, d, r); check("R10 device id", d, 32'h3);
    bus_read(12'hFC4, d, r); check("R10 offset mode", d, 32'h0);
    bus_write(12'h200, 32'hFFFF_FFFF);
    bus_read(12'h200, d, r); check("R11 unmapped read", d, 32'd0);
    bus_write(12'h0A4, 32'h1111_2222);
    bus_read(12'h0A4, d, r); check("R11 read-only context", d, 32'h0);
    check("R11 requests unchanged", {30'd0, pwr_up_req, no_pdn_req}, 32'h0);
  endtask

  initial begin
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    core_pc = '0; core_ctx = '0; core_ns = 0; core_el2 = 0; core_el3 = 0;
    core_aa64 = 0; core_vmid = '0; core_prohibit = 0; core_dlock = 0; pwr_ack = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_unlock_and_sample;
    t_prohibit;
    t_blocking;
    t_power;
    t_ids_unmapped;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule